// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block turns a stream of stereo 16-bit PCM sample pairs into a single-wire biphase-mark coded line signal of the consumer digital-audio kind. It is advanced by a one-cycle cell strobe that pulses at 128 times the sample rate. Each pulse emits one half-bit cell, so a stereo frame occupies 128 cells: a left subframe of 32 bits followed by a right subframe of 32 bits.

At the first cell of every frame the block offers a ready pulse. A source that holds a valid sample pair at that moment has both samples and the current mute setting captured for the whole frame. A source with nothing to offer gets a silent frame. The preambles and block counting carry on unchanged. One auxiliary bit in each subframe is spent as a parity-fix bit. This keeps the trailing parity bit at 0 and returns the line low at every subframe end, so the three preamble patterns can be sent as fixed cell sequences. A counter of 192 frames selects the block-start preamble.

Top module: `bmc_audio_tx`

## Requirements
- R1: After synchronous active-high reset, line_o is 0 and the frame counter is 0. The first frame's left subframe therefore starts with the block-start cells 11101000, sent first-cell-first.
- R2: line_o changes only on a clock edge at which cell_en is 1, one edge per cell. It shows cell k of the frame after the k-th strobe edge of that frame, and a frame is 128 cells long.
- R3: smp_ready is 1 only in the cell_en cycle that emits cell 0 of a frame. When smp_valid is also 1 there, left_i and right_i are captured for that frame's left and right subframes.
- R4: If smp_valid is 0 when smp_ready is 1, both subframes carry a zero sample, and the preambles and frame counting continue as normal.
- R5: Left subframes use 11100010 and right subframes always use 11100100. The block-start pattern 11101000 replaces the left pattern when the frame counter is 0, and the counter wraps after 192 frames.
- R6: Subframe bits are numbered 0 to 31. Bits 0-3 are the preamble (8 cells). Bit 4 is the parity-fix auxiliary bit, bits 5-11 are 0, bits 12-27 are the sample LSB first, and bit 28 is validity. Bits 29 (user), 30 (status) and 31 (parity) are 0.
- R7: Each of bits 4-31 starts with a line transition, and a bit of value 1 adds a second transition between its two cells.
- R8: Bit 4 equals the XOR of the sample bits and the validity bit, so bits 4-31 hold an even number of ones and every subframe ends with line_o low. For an unmuted frame, the last 8 cells of each subframe are 11001100.
- R9: When mute is 1 at the frame's ready cycle, the validity bit is 1 in both subframes of that frame and the last 8 cells of each subframe become 01001100.
- R10: Changes of left_i, right_i, smp_valid or mute after the ready cycle have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | One-cycle strobe per half-bit cell (128 x sample rate) |
| smp_valid | input | 1 | Source holds a sample pair |
| smp_ready | output | 1 | Block captures the pair this cycle (frame start) |
| left_i | input | 16 | Left channel sample |
| right_i | input | 16 | Right channel sample |
| mute | input | 1 | Mark this frame's samples invalid |
| line_o | output | 1 | Biphase-mark coded line output |

## Verification
The sample handshake, the mute capture and the emission of the first preamble cell all fall on the same strobe edge. The frame-counter advance that picks the next preamble falls on the last cell's edge. The bench provokes the first case by changing the data, validity and mute immediately after that edge in some frames. It judges the result by comparing all 128 cells with a frame built from the captured values only. The second case is exercised by running past 192 frames and checking that the block-start pattern returns exactly at the wrap, with the validity-field cell patterns checked in muted and unmuted frames.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

    localparam int SAMPLE_W        = 16;
    localparam int CELLS_PER_FRAME = 128;
    localparam int CELL_W          = $clog2(CELLS_PER_FRAME);
    localparam int SUB_CELLS       = CELLS_PER_FRAME / 2;
    localparam int PRE_CELLS       = 8;
    localparam int DATA_BITS       = 28;   // subframe bits 4..31
    localparam int SMP_OFFS        = 8;    // sample LSB at data bit index 8 (subframe bit 12)
    localparam int VAL_OFFS        = 24;   // validity at data bit index 24 (subframe bit 28)

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_LEFT  = 2'd1,
        PRE_RIGHT = 2'd2
    } pre_kind_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                invalid;
    } frame_payload_t;

    function automatic logic [PRE_CELLS-1:0] pre_cells(input pre_kind_e kind);
        case (kind)
            PRE_BLOCK: return 8'b1110_1000;
            PRE_LEFT:  return 8'b1110_0010;
            default:   return 8'b1110_0100;
        endcase
    endfunction

    // Bits 4..31 of a subframe, index 0 = subframe bit 4.
    function automatic logic [DATA_BITS-1:0] data_field(input logic [SAMPLE_W-1:0] smp,
                                                        input logic invalid);
        logic [DATA_BITS-1:0] f;
        f = '0;
        f[0] = (^smp) ^ invalid;              // parity-fix auxiliary bit
        f[SMP_OFFS +: SAMPLE_W] = smp;
        f[VAL_OFFS] = invalid;
        return f;
    endfunction

endpackage

// File: rtl/bmc_frame_timer.sv
module bmc_frame_timer
    import bmc_tx_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    localparam int FCNT_W = $clog2(BLOCK_FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_en,
    output logic [CELL_W-1:0] cell_idx,
    output logic [FCNT_W-1:0] frame_idx,
    output logic              frame_start
);
    localparam logic [CELL_W-1:0] LAST_CELL  = CELL_W'(CELLS_PER_FRAME - 1);
    localparam logic [FCNT_W-1:0] LAST_FRAME = FCNT_W'(BLOCK_FRAMES - 1);

    assign frame_start = cell_en && (cell_idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_idx  <= '0;
            frame_idx <= '0;
        end else if (cell_en) begin
            cell_idx <= cell_idx + 1'b1;
            if (cell_idx == LAST_CELL) begin
                frame_idx <= (frame_idx == LAST_FRAME) ? '0 : frame_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bmc_sample_latch.sv
module bmc_sample_latch
    import bmc_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                mute,
    output frame_payload_t      payload
);
    always_ff @(posedge clk) begin
        if (rst) begin
            payload <= '0;
        end else if (take) begin
            payload.left    <= smp_valid ? left_i  : '0;
            payload.right   <= smp_valid ? right_i : '0;
            payload.invalid <= mute;
        end
    end
endmodule

// File: rtl/bmc_cell_encoder.sv
module bmc_cell_encoder
    import bmc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_en,
    input  logic [CELL_W-1:0] cell_idx,
    input  logic              block_start,
    input  frame_payload_t    payload,
    output logic              line_o
);
    logic                 right_half;
    logic [5:0]           pos;
    logic [4:0]           bit_no;
    logic [4:0]           data_idx;
    pre_kind_e            kind;
    logic [PRE_CELLS-1:0] pre;
    logic [DATA_BITS-1:0] field;
    logic                 next_level;

    assign right_half = cell_idx[CELL_W-1];
    assign pos        = cell_idx[5:0];
    assign bit_no     = pos[5:1];
    assign data_idx   = bit_no - 5'd4;

    always_comb begin
        if (right_half)       kind = PRE_RIGHT;
        else if (block_start) kind = PRE_BLOCK;
        else                  kind = PRE_LEFT;
        pre   = pre_cells(kind);
        field = data_field(right_half ? payload.right : payload.left, payload.invalid);
        if (pos < 6'(PRE_CELLS)) begin
            next_level = pre[3'd7 - pos[2:0]];
        end else if (!pos[0]) begin
            next_level = ~line_o;                      // transition at every bit start
        end else begin
            next_level = field[data_idx] ? ~line_o : line_o;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          line_o <= 1'b0;
        else if (cell_en) line_o <= next_level;
    end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
    import bmc_tx_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cell_en,
    input  logic        smp_valid,
    output logic        smp_ready,
    input  logic [15:0] left_i,
    input  logic [15:0] right_i,
    input  logic        mute,
    output logic        line_o
);
    localparam int FCNT_W = $clog2(BLOCK_FRAMES);

    logic [CELL_W-1:0]   cell_idx;
    logic [FCNT_W-1:0]   frame_idx;
    logic                frame_start;
    frame_payload_t      payload;
    logic [SAMPLE_W-1:0] held_left;

    assign smp_ready = frame_start;
    assign held_left = payload.left;

    bmc_frame_timer #(.BLOCK_FRAMES(BLOCK_FRAMES)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .cell_en     (cell_en),
        .cell_idx    (cell_idx),
        .frame_idx   (frame_idx),
        .frame_start (frame_start)
    );

    bmc_sample_latch latch_i (
        .clk       (clk),
        .rst       (rst),
        .take      (frame_start),
        .smp_valid (smp_valid),
        .left_i    (left_i),
        .right_i   (right_i),
        .mute      (mute),
        .payload   (payload)
    );

    bmc_cell_encoder enc_i (
        .clk         (clk),
        .rst         (rst),
        .cell_en     (cell_en),
        .cell_idx    (cell_idx),
        .block_start (frame_idx == '0),
        .payload     (payload),
        .line_o      (line_o)
    );
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk #(
    parameter int BLOCK_FRAMES = 192,
    localparam int FCNT_W = $clog2(BLOCK_FRAMES)
) (
    input logic              clk,
    input logic              rst,
    input logic              cell_en,
    input logic              line_o,
    input logic              smp_ready,
    input logic              smp_valid,
    input logic [15:0]       left_i,
    input logic [15:0]       held_left,
    input logic [6:0]        cell_idx,
    input logic [FCNT_W-1:0] frame_idx
);
    localparam logic [FCNT_W-1:0] LAST_FRAME = FCNT_W'(BLOCK_FRAMES - 1);

    assert_hold_between_cells_R2: assert property (@(posedge clk) disable iff (rst)
        !cell_en |=> $stable(line_o));

    assert_bit_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cell_idx[5:0] >= 6'd8 && !cell_idx[0]) |=> (line_o != $past(line_o)));

    assert_subframe_ends_low_R8: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cell_idx[5:0] == 6'd63) |=> !line_o);

    assert_block_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (cell_en && cell_idx == 7'd127) |=>
            (frame_idx == (($past(frame_idx) == LAST_FRAME) ? '0 : $past(frame_idx) + 1'b1)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (smp_ready && smp_valid) |=> (held_left == $past(left_i)));
endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cell_en   (cell_en),
    .line_o    (line_o),
    .smp_ready (smp_ready),
    .smp_valid (smp_valid),
    .left_i    (left_i),
    .held_left (held_left),
    .cell_idx  (cell_idx),
    .frame_idx (frame_idx)
);

// File: tb/bmc_audio_tx_tb.sv
module bmc_audio_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cell_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [15:0] left_i = '0;
    logic [15:0] right_i = '0;
    logic        mute = 1'b0;
    logic        line_o;

    int checks = 0;
    int errors = 0;
    int fidx = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bmc_audio_tx dut_i (
        .clk(clk), .rst(rst), .cell_en(cell_en), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .left_i(left_i), .right_i(right_i),
        .mute(mute), .line_o(line_o)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected frame, index c = cell c of the frame.
    function automatic logic [127:0] model(input logic [15:0] l, input logic [15:0] r,
                                           input bit vld, input bit mt, input bit blk);
        logic [127:0] f;
        logic [15:0]  s;
        logic [7:0]   pre;
        logic         lvl;
        logic         d;
        f = '0;
        for (int sub = 0; sub < 2; sub++) begin
            s   = vld ? (sub == 1 ? r : l) : 16'h0;
            pre = (sub == 1) ? 8'b11100100 : (blk ? 8'b11101000 : 8'b11100010);
            for (int i = 0; i < 8; i++) f[sub*64 + i] = pre[7-i];
            lvl = pre[0];
            for (int j = 4; j < 32; j++) begin
                if (j == 4)                  d = (^s) ^ mt;
                else if (j >= 12 && j <= 27) d = s[j-12];
                else if (j == 28)            d = mt;
                else                         d = 1'b0;
                lvl = ~lvl;
                f[sub*64 + 2*j] = lvl;
                if (d) lvl = ~lvl;
                f[sub*64 + 2*j + 1] = lvl;
            end
        end
        return f;
    endfunction

    function automatic logic [7:0] cells8(input logic [127:0] f, input int base);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = f[base + i];
        return v;
    endfunction

    // Runs one frame; called at a negedge with cell_en low.
    task automatic run_frame(input logic [15:0] l, input logic [15:0] r, input bit vld,
                             input bit mt, input bit perturb, output logic [127:0] got);
        bit ready_mid_bad = 1'b0;
        left_i = l; right_i = r; smp_valid = vld; mute = mt; cell_en = 1'b1;
        #1;
        check(smp_ready === 1'b1, "R3 ready at frame start", {127'b0, smp_ready}, 128'd1);
        for (int c = 0; c < 128; c++) begin
            if (c > 0) begin
                cell_en = 1'b1;
                #1;
                if (smp_ready !== 1'b0) ready_mid_bad = 1'b1;
            end
            @(negedge clk);
            got[c] = line_o;
            cell_en = 1'b0;
            if (c == 0) begin
                if (perturb) begin
                    left_i = ~l; right_i = l ^ r ^ 16'h5A5A;
                    smp_valid = ~vld; mute = ~mt;
                end else begin
                    smp_valid = 1'b0;
                end
            end
            @(negedge clk);
        end
        check(!ready_mid_bad, "R3 ready low mid-frame", {127'b0, ready_mid_bad}, 128'd0);
    endtask

    task automatic frame_and_compare(input logic [15:0] l, input logic [15:0] r,
                                     input bit vld, input bit mt, input bit perturb,
                                     input string req, output logic [127:0] got);
        logic [127:0] exp;
        exp = model(l, r, vld, mt, fidx == 0);
        run_frame(l, r, vld, mt, perturb, got);
        check(got === exp, req, got, exp);
        fidx = (fidx + 1) % 192;
    endtask

    initial begin
        logic [127:0] got;
        logic [15:0] l, r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(line_o === 1'b0, "R1 line low after reset", {127'b0, line_o}, 128'd0);
        check(smp_ready === 1'b0, "R1 no ready without strobe", {127'b0, smp_ready}, 128'd0);
        // R2: no strobe, no change
        repeat (5) @(negedge clk);
        check(line_o === 1'b0, "R2 idle without strobe", {127'b0, line_o}, 128'd0);

        // Frame 0: block start (R1, R5, R6, R7)
        frame_and_compare(16'h1234, 16'hA5F0, 1'b1, 1'b0, 1'b0, "R6 R7 first frame", got);
        check(cells8(got, 0) === 8'b11101000, "R1 block-start preamble",
              {120'b0, cells8(got, 0)}, {120'b0, 8'b11101000});
        check(cells8(got, 64) === 8'b11100100, "R5 right preamble",
              {120'b0, cells8(got, 64)}, {120'b0, 8'b11100100});
        check(cells8(got, 56) === 8'b11001100, "R8 valid VUCP cells left",
              {120'b0, cells8(got, 56)}, {120'b0, 8'b11001100});
        check(cells8(got, 120) === 8'b11001100, "R8 valid VUCP cells right",
              {120'b0, cells8(got, 120)}, {120'b0, 8'b11001100});

        // Frame 1: left preamble, all-ones/zeros
        frame_and_compare(16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0, "R7 extremes", got);
        check(cells8(got, 0) === 8'b11100010, "R5 left preamble",
              {120'b0, cells8(got, 0)}, {120'b0, 8'b11100010});

        // Mute frame (R9)
        frame_and_compare(16'h8001, 16'h7FFE, 1'b1, 1'b1, 1'b0, "R9 muted frame", got);
        check(cells8(got, 56) === 8'b01001100, "R9 muted VUCP cells left",
              {120'b0, cells8(got, 56)}, {120'b0, 8'b01001100});
        check(cells8(got, 120) === 8'b01001100, "R9 muted VUCP cells right",
              {120'b0, cells8(got, 120)}, {120'b0, 8'b01001100});

        // No sample offered (R4), muted and not
        frame_and_compare(16'hBEEF, 16'hCAFE, 1'b0, 1'b0, 1'b0, "R4 silence", got);
        frame_and_compare(16'hBEEF, 16'hCAFE, 1'b0, 1'b1, 1'b0, "R4 R9 muted silence", got);

        // Mid-frame changes ignored (R10)
        frame_and_compare(16'h0F0F, 16'hF00F, 1'b1, 1'b0, 1'b1, "R10 mid-frame change", got);
        frame_and_compare(16'h3C3C, 16'h0001, 1'b1, 1'b1, 1'b1, "R10 mid-frame unmute", got);
        frame_and_compare(16'h4444, 16'h2222, 1'b0, 1'b0, 1'b1, "R10 mid-frame valid", got);

        // Sweep through the block wrap (R5, R6, R7, R8)
        for (int n = 0; fidx != 2 || n < 10; n++) begin
            l = 16'(n * 16'h3B1D) ^ 16'h5A5A;
            r = 16'(n * 16'h0F31 + 16'h1111);
            if (fidx == 0) begin
                frame_and_compare(l, r, 1'b1, n[2], 1'b0, "R5 block start after wrap", got);
                check(cells8(got, 0) === 8'b11101000, "R5 block-start repeats at 192",
                      {120'b0, cells8(got, 0)}, {120'b0, 8'b11101000});
            end else begin
                frame_and_compare(l, r, n[3:0] != 4'd5, n[2], n[1] & n[0], "R6 R8 sweep", got);
            end
            if (n > 400) break;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule